// File: doc/BRIEF.md
# Channel Fault Latch and Alert Controller

This block collects fault reports for a bank of LED bypass channels and turns them into held status, protective actions and a shared interrupt. Comparators elsewhere deliver one-cycle pulses for an open string or a shorted LED on each channel, plus an over-temperature flag. Each report is captured in a sticky status bit that stays set until the register interface issues a clear command, even after the condition itself has gone away.

An open string is dangerous to keep dimming, so a latched open fault forces that channel's switch on (bypassing the string) and suspends its PWM counter. A shorted LED is only reported and the channel keeps dimming. Over-temperature has its own status bit and forces nothing. Any newly latched fault pulls the active-low alert line low. The host finds the alerting device with an alert-response read; once this device has answered, the line is released until a further fault is newly latched. When the enable input is low the block is in shutdown: the open and short status words read all ones, the alert is released, no channel is bypassed, and every latch is held clear, so nothing written or detected during shutdown survives the next enable.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After a synchronous reset with enable high, all open, short and overheat status bits are 0, no bypass or PWM-suspend bit is set, and alert_n_o is 1.
- R2: An open-fault pulse on channel i while enabled sets bit i of open_sts_o, bypass_o and pwm_hold_o on the next clock edge; bits of other channels do not change.
- R3: A short-fault pulse on channel i while enabled sets bit i of short_sts_o on the next edge and leaves bypass_o and pwm_hold_o at 0.
- R4: overheat_i high while enabled sets ovht_sts_o on the next edge and sets no bit of bypass_o or pwm_hold_o.
- R5: Status bits are sticky: they stay set with no further pulses until clear_i, which clears every status, bypass and suspend bit and releases the alert on the next edge.
- R6: A detection pulse in the same cycle as clear_i wins: its bit is set after that edge and the alert is driven low.
- R7: alert_n_o goes to 0 on the edge after any status bit is newly set (was 0, becomes 1).
- R8: ara_hit_i releases alert_n_o to 1 on the next edge while the status bits stay set; a pulse on an already-set bit does not reassert the alert, a pulse that newly sets a bit does.
- R9: With enable_i low, from the next edge open_sts_o and short_sts_o read all ones, ovht_sts_o reads 0, bypass_o and pwm_hold_o are 0 and alert_n_o is 1; fault pulses and clear_i have no effect.
- R10: After enable_i rises, status starts all clear (faults seen before shutdown or during it are gone) and new faults latch normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | 1 = operating, 0 = shutdown |
| open_pulse_i | input | N_CH | Per-channel open-string detection pulses |
| short_pulse_i | input | N_CH | Per-channel shorted-LED detection pulses |
| overheat_i | input | 1 | Over-temperature flag |
| clear_i | input | 1 | Clear-all-faults command from the register interface |
| ara_hit_i | input | 1 | This device has answered an alert-response read |
| open_sts_o | output | N_CH | Latched open-fault status (all ones in shutdown) |
| short_sts_o | output | N_CH | Latched short-fault status (all ones in shutdown) |
| ovht_sts_o | output | 1 | Latched overheat status |
| bypass_o | output | N_CH | Force channel switch on |
| pwm_hold_o | output | N_CH | Suspend channel PWM dimming |
| alert_n_o | output | 1 | Active-low interrupt request, released when 1 |

## Verification
Open, short and overheat reports are applied one class at a time on different channels, which separates the bypass and PWM-suspend path from the report-only paths and catches a swapped or shared channel index. Clear is applied alone and together with a fresh pulse, telling a set-wins latch from a clear-wins one. The alert-response sequence pulses an already-latched channel and then a fresh one, distinguishing edge-based from level-based alert re-arming. A shutdown with a fault latched, with pulses and clear applied while disabled, then re-enable, shows both the all-ones shutdown readout and that no state survives.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;

  // Alert request state
  typedef enum logic {
    ALR_IDLE = 1'b0,
    ALR_PEND = 1'b1
  } alert_state_e;

  // Kinds of fault sources feeding the alert
  typedef enum logic [1:0] {
    SRC_OPEN  = 2'd0,
    SRC_SHORT = 2'd1,
    SRC_HEAT  = 2'd2
  } fault_src_e;

  localparam int NUM_SRC = 3;

endpackage

// File: rtl/fault_bit_latch.sv
module fault_bit_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o,
  output logic         new_o
);

  logic [W-1:0] q;
  logic [W-1:0] fresh;

  // A bit is fresh when it is being set and was not held before
  assign fresh = en ? (set_i & ~q) : '0;
  assign new_o = |fresh;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || !en) begin
        q[b] <= 1'b0;
      end else if (set_i[b]) begin
        q[b] <= 1'b1;          // detection beats clear
      end else if (clr_i) begin
        q[b] <= 1'b0;
      end
    end
  end

  assign q_o = q;

endmodule

// File: rtl/alert_arbiter.sv
module alert_arbiter
  import fault_alert_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [N_SRC-1:0] fresh_i,
  input  logic             ara_i,
  input  logic             clr_i,
  output logic             alert_n_o
);

  alert_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = ALR_IDLE;
    end else if (|fresh_i) begin
      state_d = ALR_PEND;
    end else if (ara_i || clr_i) begin
      state_d = ALR_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ALR_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign alert_n_o = (state_q != ALR_PEND);

endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
  import fault_alert_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable_i,
  input  logic [N_CH-1:0] open_pulse_i,
  input  logic [N_CH-1:0] short_pulse_i,
  input  logic            overheat_i,
  input  logic            clear_i,
  input  logic            ara_hit_i,
  output logic [N_CH-1:0] open_sts_o,
  output logic [N_CH-1:0] short_sts_o,
  output logic            ovht_sts_o,
  output logic [N_CH-1:0] bypass_o,
  output logic [N_CH-1:0] pwm_hold_o,
  output logic            alert_n_o
);

  localparam logic [N_CH-1:0] ALL_ONES = {N_CH{1'b1}};

  logic            en_q;
  logic [N_CH-1:0] open_q;
  logic [N_CH-1:0] short_q;
  logic [0:0]      heat_q;
  logic [NUM_SRC-1:0] fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else begin
      en_q <= enable_i;
    end
  end

  fault_bit_latch #(.W(N_CH)) u_open (
    .clk   (clk),
    .rst   (rst),
    .en    (enable_i),
    .set_i (open_pulse_i),
    .clr_i (clear_i),
    .q_o   (open_q),
    .new_o (fresh[SRC_OPEN])
  );

  fault_bit_latch #(.W(N_CH)) u_short (
    .clk   (clk),
    .rst   (rst),
    .en    (enable_i),
    .set_i (short_pulse_i),
    .clr_i (clear_i),
    .q_o   (short_q),
    .new_o (fresh[SRC_SHORT])
  );

  fault_bit_latch #(.W(1)) u_heat (
    .clk   (clk),
    .rst   (rst),
    .en    (enable_i),
    .set_i (overheat_i),
    .clr_i (clear_i),
    .q_o   (heat_q),
    .new_o (fresh[SRC_HEAT])
  );

  alert_arbiter #(.N_SRC(NUM_SRC)) u_alert (
    .clk       (clk),
    .rst       (rst),
    .en        (enable_i),
    .fresh_i   (fresh),
    .ara_i     (ara_hit_i),
    .clr_i     (clear_i),
    .alert_n_o (alert_n_o)
  );

  // Status readout: shutdown shows all ones on the LED fault words
  assign open_sts_o  = en_q ? open_q  : ALL_ONES;
  assign short_sts_o = en_q ? short_q : ALL_ONES;
  assign ovht_sts_o  = en_q & heat_q[0];

  // Only an open string forces bypass and suspends dimming
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign bypass_o[c]   = en_q & open_q[c];
    assign pwm_hold_o[c] = en_q & open_q[c];
  end

endmodule

// File: rtl/fault_alert_chk.sv
module fault_alert_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            enable_i,
  input logic [N_CH-1:0] open_pulse_i,
  input logic [N_CH-1:0] short_pulse_i,
  input logic            overheat_i,
  input logic            clear_i,
  input logic            ara_hit_i,
  input logic [N_CH-1:0] open_sts_o,
  input logic [N_CH-1:0] short_sts_o,
  input logic            ovht_sts_o,
  input logic [N_CH-1:0] bypass_o,
  input logic [N_CH-1:0] pwm_hold_o,
  input logic            alert_n_o
);

  // R2
  open_sets_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    enable_i |=> ((bypass_o & $past(open_pulse_i)) == $past(open_pulse_i)));

  // R4
  heat_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && overheat_i) |=> ovht_sts_o);

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && clear_i && open_pulse_i == '0 && short_pulse_i == '0 && !overheat_i)
    |=> (open_sts_o == '0 && short_sts_o == '0 && !ovht_sts_o && alert_n_o));

  // R7
  new_fault_alert_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && $past(enable_i) && !$past(rst) &&
     (|(open_pulse_i & ~open_sts_o) || |(short_pulse_i & ~short_sts_o)))
    |=> !alert_n_o);

  // R8
  ara_release_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && ara_hit_i && open_pulse_i == '0 && short_pulse_i == '0 && !overheat_i)
    |=> alert_n_o);

  // R9
  shutdown_safe_chk: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (bypass_o == '0 && pwm_hold_o == '0 && alert_n_o &&
                   open_sts_o == '1 && short_sts_o == '1));

  // R3
  short_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && $past(enable_i) && !$past(rst) && !clear_i && open_pulse_i == '0)
    |=> $stable(pwm_hold_o));

endmodule

bind fault_alert_ctrl fault_alert_chk #(.N_CH(N_CH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .enable_i      (enable_i),
  .open_pulse_i  (open_pulse_i),
  .short_pulse_i (short_pulse_i),
  .overheat_i    (overheat_i),
  .clear_i       (clear_i),
  .ara_hit_i     (ara_hit_i),
  .open_sts_o    (open_sts_o),
  .short_sts_o   (short_sts_o),
  .ovht_sts_o    (ovht_sts_o),
  .bypass_o      (bypass_o),
  .pwm_hold_o    (pwm_hold_o),
  .alert_n_o     (alert_n_o)
);

// File: tb/fault_alert_ctrl_bench.sv
`timescale 1ns/1ps
module fault_alert_ctrl_bench;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable_i = 1'b1;
  logic [N-1:0] open_pulse_i = '0;
  logic [N-1:0] short_pulse_i = '0;
  logic         overheat_i = 1'b0;
  logic         clear_i = 1'b0;
  logic         ara_hit_i = 1'b0;
  logic [N-1:0] open_sts_o, short_sts_o, bypass_o, pwm_hold_o;
  logic         ovht_sts_o, alert_n_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_alert_ctrl #(.N_CH(N)) u_fault_alert_ctrl (
    .clk(clk), .rst(rst), .enable_i(enable_i),
    .open_pulse_i(open_pulse_i), .short_pulse_i(short_pulse_i),
    .overheat_i(overheat_i), .clear_i(clear_i), .ara_hit_i(ara_hit_i),
    .open_sts_o(open_sts_o), .short_sts_o(short_sts_o), .ovht_sts_o(ovht_sts_o),
    .bypass_o(bypass_o), .pwm_hold_o(pwm_hold_o), .alert_n_o(alert_n_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock edge, then sample at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    open_pulse_i = '0; short_pulse_i = '0; overheat_i = 1'b0;
    clear_i = 1'b0; ara_hit_i = 1'b0;
  endtask

  task automatic do_clear();
    clear_i = 1'b1; step();
  endtask

  task automatic t_reset();
    rst = 1'b1; enable_i = 1'b1;
    repeat (3) step();
    rst = 1'b0; step();
    check("R1 open",    open_sts_o, 0);
    check("R1 short",   short_sts_o, 0);
    check("R1 ovht",    ovht_sts_o, 0);
    check("R1 bypass",  bypass_o, 0);
    check("R1 hold",    pwm_hold_o, 0);
    check("R1 alert_n", alert_n_o, 1);
  endtask

  task automatic t_open();
    open_pulse_i = 8'h04; step();
    check("R2 open",   open_sts_o, 8'h04);
    check("R2 bypass", bypass_o, 8'h04);
    check("R2 hold",   pwm_hold_o, 8'h04);
    check("R2 short",  short_sts_o, 0);
    check("R7 alert",  alert_n_o, 0);
    repeat (3) step();
    check("R5 sticky", open_sts_o, 8'h04);
    do_clear();
    check("R5 clr open",   open_sts_o, 0);
    check("R5 clr bypass", bypass_o, 0);
    check("R5 clr alert",  alert_n_o, 1);
  endtask

  task automatic t_short();
    short_pulse_i = 8'h20; step();
    check("R3 short",  short_sts_o, 8'h20);
    check("R3 bypass", bypass_o, 0);
    check("R3 hold",   pwm_hold_o, 0);
    check("R7 alert",  alert_n_o, 0);
    do_clear();
    check("R5 clr short", short_sts_o, 0);
  endtask

  task automatic t_heat();
    overheat_i = 1'b1; step();
    check("R4 ovht",   ovht_sts_o, 1);
    check("R4 bypass", bypass_o, 0);
    check("R7 alert",  alert_n_o, 0);
    step();
    check("R5 ovht sticky", ovht_sts_o, 1);
    do_clear();
    check("R5 clr ovht", ovht_sts_o, 0);
  endtask

  task automatic t_race();
    open_pulse_i = 8'h02; step();
    clear_i = 1'b1; open_pulse_i = 8'h40; step();
    check("R6 open",  open_sts_o, 8'h40);
    check("R6 alert", alert_n_o, 0);
    do_clear();
  endtask

  task automatic t_ara();
    open_pulse_i = 8'h01; step();
    check("R7 alert", alert_n_o, 0);
    ara_hit_i = 1'b1; step();
    check("R8 released", alert_n_o, 1);
    check("R8 kept",     open_sts_o, 8'h01);
    open_pulse_i = 8'h01; step();
    check("R8 repeat no alert", alert_n_o, 1);
    open_pulse_i = 8'h08; step();
    check("R8 fresh alert", alert_n_o, 0);
    do_clear();
  endtask

  task automatic t_shutdown();
    open_pulse_i = 8'h10; step();
    enable_i = 1'b0; step();
    check("R9 open",   open_sts_o, 8'hFF);
    check("R9 short",  short_sts_o, 8'hFF);
    check("R9 ovht",   ovht_sts_o, 0);
    check("R9 bypass", bypass_o, 0);
    check("R9 hold",   pwm_hold_o, 0);
    check("R9 alert",  alert_n_o, 1);
    open_pulse_i = 8'h02; short_pulse_i = 8'h02; clear_i = 1'b1; step();
    check("R9 ignore bypass", bypass_o, 0);
    check("R9 ignore alert",  alert_n_o, 1);
    enable_i = 1'b1; step();
    check("R10 open",   open_sts_o, 0);
    check("R10 short",  short_sts_o, 0);
    check("R10 bypass", bypass_o, 0);
    check("R10 alert",  alert_n_o, 1);
    open_pulse_i = 8'h80; step();
    check("R10 relatch", open_sts_o, 8'h80);
    do_clear();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_open();
    t_short();
    t_heat();
    t_race();
    t_ara();
    t_shutdown();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule